// File: doc/BRIEF.md
# Multi-Mode Up/Down Position Counter

This block is the count core of one motion axis. Each clock cycle it may receive a single count pulse with a direction bit. It steps a 24-bit register in pure binary or in six packed decimal digits. How the register behaves at its boundaries depends on the selected boundary mode: it can wrap freely, stop at a limit, stop after one full cycle, or divide by a programmable modulus in both directions. A 24-bit preset input supplies the limit and modulus values, the comparison value and the load value.

The block keeps a status byte. The byte holds edge-toggled bits for carry, borrow and compare, plus level bits for sign, direction, input noise and index. Three active-low outputs each pulse for one clock when a carry, borrow or compare occurs. Command strobes reset the count, load it from the preset, clear the status bits and copy the count into a holding latch. All of these act on the whole word in a single cycle. The decoding of the input pulses and the host register interface sit outside this block.

Top module: `mmode_counter`

## Requirements
- R1: While `rst` is high at a clock edge, and after it, `count`, `latch` and `status` are 0 and `carry_n`, `borrow_n`, `compare_n` are 1.
- R2: Mode `2'd0` (wrap), binary: an accepted up pulse at FFFFFF gives 000000, and a down pulse at 000000 gives FFFFFF. `carry_n` (up) or `borrow_n` (down) is low for exactly the one cycle in which the new count first appears. Any other step is plus or minus one.
- R3: With `bcd` high, each nibble is a decimal digit. Up from 999999 gives 000000 with a carry, and down from 000000 gives 999999 with a borrow. Steps cross digit boundaries in decimal (000009 up gives 000010).
- R4: Mode `2'd1` (clamp): an up pulse while count equals `preset` leaves the count unchanged, and so does a down pulse while count is 0. Neither produces a carry or borrow. Counting resumes as soon as a pulse arrives in the other direction.
- R5: Mode `2'd2` (one-shot): the wrap that produces a carry or borrow also halts counting. Later pulses are ignored until a reset or load command.
- R6: Mode `2'd3` (modulo): an up pulse at count equal to `preset` gives 0 with a carry. A down pulse at 0 gives `preset` with a borrow.
- R7: When an accepted step makes count equal to `preset`, `compare_n` is low for that one cycle and status bit 2 toggles.
- R8: Status layout: bit0 toggles on each borrow, bit1 toggles on each carry, bit3 is set by a borrow and cleared by a carry, bit5 holds the direction of the last accepted pulse (1 = up), and bit7 is always 0.
- R9: Bit4 is set by `noise_evt` and is cleared only by `cmd_err_clr`. `cmd_flag_clr` clears bits 0 to 3 and leaves bit4. Bit6 follows `index_in` one cycle later.
- R10: `cmd_reset` sets count to 0 and `cmd_load` copies `preset` into it, and reset wins when both are given. A count pulse given in the same cycle as either command is dropped.
- R11: `cmd_latch` copies the current count into `latch`, which is visible on the next cycle.
- R12: With no count pulse and no command, the count holds.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cnt_en | input | 1 | One-cycle count pulse |
| cnt_up | input | 1 | Direction of the pulse, 1 = up |
| preset | input | 24 | Limit, modulus, comparison and load value |
| mode | input | 2 | Boundary mode: 0 wrap, 1 clamp, 2 one-shot, 3 modulo |
| bcd | input | 1 | 1 = decimal digit counting |
| cmd_load | input | 1 | Load count from preset |
| cmd_reset | input | 1 | Clear count |
| cmd_flag_clr | input | 1 | Clear status bits 0 to 3 |
| cmd_err_clr | input | 1 | Clear status bit 4 |
| cmd_latch | input | 1 | Copy count to latch |
| noise_evt | input | 1 | Sets the noise bit |
| index_in | input | 1 | Index level sampled into bit 6 |
| count | output | 24 | Current count |
| latch | output | 24 | Held copy of the count |
| status | output | 8 | Status byte |
| carry_n | output | 1 | Active-low carry pulse |
| borrow_n | output | 1 | Active-low borrow pulse |
| compare_n | output | 1 | Active-low compare pulse |

## Verification
The bench targets every boundary in every mode. It checks the binary and decimal wraps, where a design with a wrong digit chain would produce A or F nibbles, or would miss the pulse. It checks that a clamped count does not step past the preset and does not wrap below zero. It checks that a halted one-shot counter ignores pulses in both directions until it is reloaded, and that a modulo counter reloads the preset on the way down, not FFFFFF. It also checks command-versus-pulse collisions, where a wrong priority would show up as preset+1, and that a flag clear does not touch the noise bit.

// File: rtl/cnt_pkg.sv
package cnt_pkg;
  typedef enum logic [1:0] {
    MODE_WRAP    = 2'd0,
    MODE_CLAMP   = 2'd1,
    MODE_ONESHOT = 2'd2,
    MODE_MODN    = 2'd3
  } cnt_mode_e;
endpackage

// File: rtl/cnt_arith.sv
// Next-value step in binary or packed decimal, plus boundary detect.
module cnt_arith #(
  parameter int WIDTH = 24
) (
  input  logic [WIDTH-1:0] val,
  input  logic             up,
  input  logic             bcd,
  output logic [WIDTH-1:0] nxt,
  output logic             edge_hit
);
  localparam int DIGITS = WIDTH / 4;

  logic [WIDTH-1:0] bin_nxt, dec_nxt;
  logic [DIGITS:0]  chain;

  assign bin_nxt  = up ? val + 1'b1 : val - 1'b1;
  assign chain[0] = 1'b1;

  for (genvar g = 0; g < DIGITS; g++) begin : g_dig
    logic [3:0] d, r;
    logic       lim;
    assign d   = val[4*g +: 4];
    assign lim = up ? (d >= 4'd9) : (d == 4'd0);
    always_comb begin
      r = d;
      if (chain[g]) begin
        if (up) r = lim ? 4'd0 : d + 4'd1;
        else    r = lim ? 4'd9 : d - 4'd1;
      end
    end
    assign chain[g+1]        = chain[g] & lim;
    assign dec_nxt[4*g +: 4] = r;
  end

  assign nxt      = bcd ? dec_nxt : bin_nxt;
  assign edge_hit = bcd ? chain[DIGITS] : (up ? &val : ~|val);
endmodule

// File: rtl/cnt_flags.sv
// Status byte: toggles, sign, noise, direction, index.
module cnt_flags (
  input  logic       clk,
  input  logic       rst,
  input  logic       step,
  input  logic       up,
  input  logic       carry_ev,
  input  logic       borrow_ev,
  input  logic       cmp_ev,
  input  logic       flag_clr,
  input  logic       err_clr,
  input  logic       noise,
  input  logic       index,
  output logic [7:0] status
);
  logic bt, ct, cpt, sgn, err, ud, idx;

  always_ff @(posedge clk) begin
    if (rst) begin
      bt <= 1'b0; ct <= 1'b0; cpt <= 1'b0; sgn <= 1'b0;
      err <= 1'b0; ud <= 1'b0; idx <= 1'b0;
    end else begin
      if (flag_clr) begin
        bt <= 1'b0; ct <= 1'b0; cpt <= 1'b0; sgn <= 1'b0;
      end else begin
        if (borrow_ev) begin bt <= ~bt; sgn <= 1'b1; end
        if (carry_ev)  begin ct <= ~ct; sgn <= 1'b0; end
        if (cmp_ev)    cpt <= ~cpt;
      end
      if (step) ud <= up;
      if (noise)        err <= 1'b1;
      else if (err_clr) err <= 1'b0;
      idx <= index;
    end
  end

  assign status = {1'b0, idx, ud, err, sgn, cpt, ct, bt};
endmodule

// File: rtl/mmode_counter.sv
module mmode_counter #(
  parameter int WIDTH = 24
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             cnt_en,
  input  logic             cnt_up,
  input  logic [WIDTH-1:0] preset,
  input  logic [1:0]       mode,
  input  logic             bcd,
  input  logic             cmd_load,
  input  logic             cmd_reset,
  input  logic             cmd_flag_clr,
  input  logic             cmd_err_clr,
  input  logic             cmd_latch,
  input  logic             noise_evt,
  input  logic             index_in,
  output logic [WIDTH-1:0] count,
  output logic [WIDTH-1:0] latch,
  output logic [7:0]       status,
  output logic             carry_n,
  output logic             borrow_n,
  output logic             compare_n
);
  import cnt_pkg::*;

  cnt_mode_e        md;
  logic [WIDTH-1:0] cnt_q, latch_q, step_val, cnt_d;
  logic             halt_q, halt_d, edge_hit, take, moved;
  logic             at_pre, at_zero, carry_ev, borrow_ev, cmp_ev;

  assign md      = cnt_mode_e'(mode);
  assign at_pre  = (cnt_q == preset);
  assign at_zero = (cnt_q == '0);
  assign take    = cnt_en & ~cmd_load & ~cmd_reset &
                   ~((md == MODE_ONESHOT) & halt_q);

  cnt_arith #(.WIDTH(WIDTH)) u_arith (
    .val(cnt_q), .up(cnt_up), .bcd(bcd), .nxt(step_val), .edge_hit(edge_hit)
  );

  always_comb begin
    cnt_d     = cnt_q;
    halt_d    = halt_q;
    moved     = 1'b0;
    carry_ev  = 1'b0;
    borrow_ev = 1'b0;
    if (cmd_reset) begin
      cnt_d  = '0;
      halt_d = 1'b0;
    end else if (cmd_load) begin
      cnt_d  = preset;
      halt_d = 1'b0;
    end else if (take) begin
      case (md)
        MODE_CLAMP: begin
          if (!(cnt_up ? at_pre : at_zero)) begin
            cnt_d     = step_val;
            moved     = 1'b1;
            carry_ev  = cnt_up & edge_hit;
            borrow_ev = ~cnt_up & edge_hit;
          end
        end
        MODE_MODN: begin
          moved = 1'b1;
          if (cnt_up && at_pre) begin
            cnt_d    = '0;
            carry_ev = 1'b1;
          end else if (!cnt_up && at_zero) begin
            cnt_d     = preset;
            borrow_ev = 1'b1;
          end else begin
            cnt_d = step_val;
          end
        end
        default: begin
          cnt_d     = step_val;
          moved     = 1'b1;
          carry_ev  = cnt_up & edge_hit;
          borrow_ev = ~cnt_up & edge_hit;
          if (md == MODE_ONESHOT && edge_hit) halt_d = 1'b1;
        end
      endcase
    end
  end

  assign cmp_ev = moved & (cnt_d == preset);

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q     <= '0;
      latch_q   <= '0;
      halt_q    <= 1'b0;
      carry_n   <= 1'b1;
      borrow_n  <= 1'b1;
      compare_n <= 1'b1;
    end else begin
      cnt_q     <= cnt_d;
      halt_q    <= halt_d;
      if (cmd_latch) latch_q <= cnt_q;
      carry_n   <= ~carry_ev;
      borrow_n  <= ~borrow_ev;
      compare_n <= ~cmp_ev;
    end
  end

  cnt_flags u_flags (
    .clk(clk), .rst(rst), .step(take), .up(cnt_up),
    .carry_ev(carry_ev), .borrow_ev(borrow_ev), .cmp_ev(cmp_ev),
    .flag_clr(cmd_flag_clr), .err_clr(cmd_err_clr),
    .noise(noise_evt), .index(index_in), .status(status)
  );

  assign count = cnt_q;
  assign latch = latch_q;
endmodule

// File: rtl/cnt_checker.sv
module cnt_checker #(
  parameter int WIDTH = 24
) (
  input logic             clk,
  input logic             rst,
  input logic             cnt_en,
  input logic             cnt_up,
  input logic [WIDTH-1:0] preset,
  input logic [1:0]       mode,
  input logic             cmd_load,
  input logic             cmd_reset,
  input logic             cmd_flag_clr,
  input logic             cmd_latch,
  input logic [WIDTH-1:0] count,
  input logic [WIDTH-1:0] latch,
  input logic [7:0]       status,
  input logic             carry_n,
  input logic             borrow_n
);
  assert_load_preset_R10: assert property (@(posedge clk) disable iff (rst)
    (cmd_load && !cmd_reset) |=> count == $past(preset));

  assert_reset_zero_R10: assert property (@(posedge clk) disable iff (rst)
    cmd_reset |=> count == '0);

  assert_latch_copy_R11: assert property (@(posedge clk) disable iff (rst)
    cmd_latch |=> latch == $past(count));

  assert_idle_hold_R12: assert property (@(posedge clk) disable iff (rst)
    (!cnt_en && !cmd_load && !cmd_reset) |=> $stable(count));

  assert_cb_excl_R2: assert property (@(posedge clk) disable iff (rst)
    carry_n || borrow_n);

  assert_carry_toggle_R8: assert property (@(posedge clk) disable iff (rst)
    (!carry_n && !$past(cmd_flag_clr)) |-> status[1] != $past(status[1]));

  assert_borrow_sign_R8: assert property (@(posedge clk) disable iff (rst)
    (!borrow_n && !$past(cmd_flag_clr)) |-> status[3]);

  assert_clamp_hold_R4: assert property (@(posedge clk) disable iff (rst)
    (cnt_en && cnt_up && mode == 2'd1 && count == preset &&
     !cmd_load && !cmd_reset) |=> $stable(count));
endmodule

bind mmode_counter cnt_checker #(.WIDTH(WIDTH)) u_chk (
  .clk(clk), .rst(rst), .cnt_en(cnt_en), .cnt_up(cnt_up), .preset(preset),
  .mode(mode), .cmd_load(cmd_load), .cmd_reset(cmd_reset),
  .cmd_flag_clr(cmd_flag_clr), .cmd_latch(cmd_latch), .count(count),
  .latch(latch), .status(status), .carry_n(carry_n), .borrow_n(borrow_n)
);

// File: tb/sim_mmode_counter.sv
`timescale 1ns/1ps
module sim_mmode_counter;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        cnt_en = 1'b0, cnt_up = 1'b0, bcd = 1'b0;
  logic [23:0] preset = '0;
  logic [1:0]  mode = 2'd0;
  logic        cmd_load = 1'b0, cmd_reset = 1'b0, cmd_flag_clr = 1'b0;
  logic        cmd_err_clr = 1'b0, cmd_latch = 1'b0;
  logic        noise_evt = 1'b0, index_in = 1'b0;
  logic [23:0] count, latch;
  logic [7:0]  status;
  logic        carry_n, borrow_n, compare_n;
  int checks = 0, errors = 0;
  bit done = 0;

  always #10 clk = ~clk;

  mmode_counter u0 (
    .clk(clk), .rst(rst), .cnt_en(cnt_en), .cnt_up(cnt_up), .preset(preset),
    .mode(mode), .bcd(bcd), .cmd_load(cmd_load), .cmd_reset(cmd_reset),
    .cmd_flag_clr(cmd_flag_clr), .cmd_err_clr(cmd_err_clr),
    .cmd_latch(cmd_latch), .noise_evt(noise_evt), .index_in(index_in),
    .count(count), .latch(latch), .status(status), .carry_n(carry_n),
    .borrow_n(borrow_n), .compare_n(compare_n)
  );

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // one count pulse; returns at the negedge where the result is visible
  task automatic pulse(bit up);
    @(negedge clk); cnt_en = 1'b1; cnt_up = up;
    @(negedge clk); cnt_en = 1'b0;
  endtask

  task automatic cmd(bit ld, bit rs, bit fc, bit ec, bit lt);
    @(negedge clk);
    cmd_load = ld; cmd_reset = rs; cmd_flag_clr = fc; cmd_err_clr = ec; cmd_latch = lt;
    @(negedge clk);
    cmd_load = 0; cmd_reset = 0; cmd_flag_clr = 0; cmd_err_clr = 0; cmd_latch = 0;
  endtask

  task automatic load_val(logic [23:0] v, logic [23:0] after);
    preset = v; cmd(1, 0, 0, 0, 0); preset = after;
  endtask

  task automatic t_reset();
    chk("R1 count", count, 0);
    chk("R1 latch", latch, 0);
    chk("R1 status", status, 0);
    chk("R1 pulses", {carry_n, borrow_n, compare_n}, 3'b111);
  endtask

  task automatic t_wrap_bin();
    mode = 2'd0; bcd = 0;
    load_val(24'hFFFFFE, 24'h123456);
    pulse(1); chk("R2 step", count, 24'hFFFFFF); chk("R2 no carry", carry_n, 1);
    pulse(1); chk("R2 up wrap", count, 0); chk("R2 carry low", carry_n, 0);
    chk("R8 ct/ud", status, 8'h22);
    @(negedge clk); chk("R2 carry one cycle", carry_n, 1);
    pulse(0); chk("R2 down wrap", count, 24'hFFFFFF); chk("R2 borrow low", borrow_n, 0);
    chk("R8 bt/sign/ud", status, 8'h0B);
    cmd(0, 0, 1, 0, 0); chk("R9 flag clear", status, 8'h00);
  endtask

  task automatic t_compare();
    mode = 2'd0; preset = 24'd5; cmd(0, 1, 0, 0, 0);
    for (int i = 0; i < 4; i++) pulse(1);
    chk("R7 before match", compare_n, 1);
    pulse(1); chk("R7 count", count, 5); chk("R7 compare low", compare_n, 0);
    chk("R7 cpt bit", status[2], 1);
    cmd(0, 0, 1, 0, 0);
  endtask

  task automatic t_clamp();
    mode = 2'd1; preset = 24'd3; cmd(0, 1, 0, 0, 0);
    pulse(1); pulse(1); pulse(1); chk("R4 reach", count, 3);
    pulse(1); chk("R4 hold top", count, 3); chk("R4 no carry", carry_n, 1);
    pulse(0); chk("R4 reverse", count, 2);
    pulse(0); pulse(0); pulse(0);
    chk("R4 hold zero", count, 0); chk("R4 no borrow", borrow_n, 1);
    pulse(1); chk("R4 resume up", count, 1);
  endtask

  task automatic t_oneshot();
    mode = 2'd2; bcd = 0;
    load_val(24'hFFFFFE, 24'h000010);
    pulse(1); pulse(1); chk("R5 wrap", count, 0); chk("R5 carry", carry_n, 0);
    pulse(1); chk("R5 halted up", count, 0);
    pulse(0); chk("R5 halted down", count, 0);
    cmd(0, 1, 0, 0, 0); pulse(1); chk("R5 resume after reset", count, 1);
    pulse(0); pulse(0); chk("R5 under", count, 24'hFFFFFF); chk("R5 borrow", borrow_n, 0);
    pulse(0); chk("R5 halted again", count, 24'hFFFFFF);
    cmd(1, 0, 0, 0, 0); pulse(0); chk("R5 resume after load", count, 24'h00000F);
  endtask

  task automatic t_modn();
    mode = 2'd3; preset = 24'd3; cmd(0, 1, 1, 0, 0);
    pulse(1); pulse(1); pulse(1); chk("R6 at N", count, 3);
    pulse(1); chk("R6 up to zero", count, 0); chk("R6 carry", carry_n, 0);
    pulse(0); chk("R6 down reload", count, 3); chk("R6 borrow", borrow_n, 0);
    chk("R7 compare on reload", compare_n, 0);
    pulse(0); chk("R6 continue", count, 2);
  endtask

  task automatic t_bcd();
    mode = 2'd0; bcd = 1;
    load_val(24'h999998, 24'h000050);
    pulse(1); chk("R3 step", count, 24'h999999);
    pulse(1); chk("R3 up wrap", count, 0); chk("R3 carry", carry_n, 0);
    pulse(0); chk("R3 down wrap", count, 24'h999999); chk("R3 borrow", borrow_n, 0);
    load_val(24'h000009, 24'h000050);
    pulse(1); chk("R3 digit carry", count, 24'h000010);
    pulse(0); chk("R3 digit borrow", count, 24'h000009);
    bcd = 0;
  endtask

  task automatic t_err_idx();
    cmd(0, 0, 1, 0, 0);
    @(negedge clk); noise_evt = 1; @(negedge clk); noise_evt = 0;
    chk("R9 noise set", status[4], 1);
    cmd(0, 0, 1, 0, 0); chk("R9 flag clr keeps noise", status[4], 1);
    cmd(0, 0, 0, 1, 0); chk("R9 err clr", status[4], 0);
    @(negedge clk); index_in = 1; @(negedge clk);
    chk("R9 index", status[6], 1);
    index_in = 0; @(negedge clk); chk("R9 index low", status[6], 0);
  endtask

  task automatic t_cmds();
    mode = 2'd0; preset = 24'h00ABCD;
    @(negedge clk); cnt_en = 1; cnt_up = 1; cmd_load = 1;
    @(negedge clk); cnt_en = 0; cmd_load = 0;
    chk("R10 load beats count", count, 24'h00ABCD);
    cmd(0, 0, 0, 0, 1); chk("R11 latch", latch, 24'h00ABCD);
    cmd(1, 1, 0, 0, 0); chk("R10 reset beats load", count, 0);
    chk("R11 latch kept", latch, 24'h00ABCD);
    repeat (4) @(negedge clk); chk("R12 idle hold", count, 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst = 0;
    @(negedge clk); t_reset();
    t_wrap_bin();
    t_compare();
    t_clamp();
    t_oneshot();
    t_modn();
    t_bcd();
    t_err_idx();
    t_cmds();
    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule